// File: doc/BRIEF.md
# DC Load Check Retry Sequencer

This block sits beside each output channel of a multi-channel power stage and decides whether a channel that wants to leave its high-impedance state may go on to mute or play. When the channel asks to leave high impedance while the standby input is high, the sequencer either waves it through or runs a DC load check first. A bypass control lets the channel through with no check at all. An "already passed at power-up" credit marks the channel good without testing it again. Otherwise the sequencer sends a one-cycle start pulse to an external measurement engine and waits for that engine's done pulse, which carries a pass or fault flag and four fault detail bits.

A pass sets the channel's state-report bit and releases the channel. A fault leaves the report bit low, latches the detail bits into a per-channel report field and holds the channel in high impedance. It then starts a fixed retry wait of 750 ms, counted in clock cycles. When the wait ends the test runs again. This repeats until a test passes or software clears the channel's diagnostic enable. Clearing the enable during the wait abandons the retry and keeps the last fault detail visible. Each channel runs its own copy of the sequencer and its own retry timer.

Top module: `ldg_retry_seq`

## Requirements
- R1: After reset every start pulse, report bit, release bit and detail field is 0.
- R2: A test starts only when the channel requests leaving high impedance, standby is high, bypass is low, the channel has no power-up credit and its diagnostic enable is set. The start output is then high for exactly one cycle, one clock after the request is sampled.
- R3: With bypass high and standby high, a requesting channel is released one cycle later with no start pulse, and its report bit stays 0.
- R4: With the power-up credit set, a requesting channel gets no start pulse. Its report bit and release bit go high one cycle later.
- R5: A done pulse with the fault flag low sets the report bit and the release bit on the next cycle.
- R6: A done pulse with the fault flag high keeps the report bit and the release bit at 0 and latches the detail bits, which are encoded as bit 0 short to ground, bit 1 short to supply, bit 2 shorted load and bit 3 open load.
- R7: The detail field reads 0 in every cycle in which a start pulse is out, and whenever a credit is taken.
- R8: After a fault, the retry start pulse appears WAIT_MS*CYC_PER_MS+1 cycles after the edge that sampled the faulty done pulse, provided standby is high. If standby is low at that point, the retry waits until standby returns high and fires on the next cycle.
- R9: Clearing the diagnostic enable during the retry wait cancels the retry and keeps the latched detail. If the clear and the end of the wait fall in the same cycle, the clear wins.
- R10: When the request drops, the report bit and the release bit read 0 on the next cycle.
- R11: Channels are independent. Activity on one channel leaves every output of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby input; high permits a test to start |
| bypass_i | input | 1 | Skip the check and release directly (reset value 0 in its register) |
| diag_en_i | input | NUM_CH | Per-channel diagnostic enable |
| init_pass_i | input | NUM_CH | Per-channel credit: passed the power-up check with no fault |
| req_i | input | NUM_CH | Channel requests to leave high impedance (level) |
| meas_start_o | output | NUM_CH | One-cycle start pulse to the measurement engine |
| meas_done_i | input | NUM_CH | One-cycle result pulse from the engine |
| meas_fault_i | input | NUM_CH | Result flag, valid with done: 1 = fault |
| meas_det_i | input | NUM_CH*4 | Fault detail bits, valid with done |
| report_o | output | NUM_CH | State-report bit: the check completed clean |
| release_o | output | NUM_CH | Channel may proceed to mute or play |
| det_o | output | NUM_CH*4 | Latched fault detail per channel |

## Verification
Two events can land in the same cycle: the end of the retry wait and software clearing the diagnostic enable. The bench counts cycles from the faulty result and clears the enable on the exact cycle whose edge would fire the retry. It then judges that no start pulse ever appears and that the detail field still holds the fault pattern. A second pairing drops standby before the wait ends. This shows that a finished wait does not fire on its own, and that the retry fires one cycle after standby returns.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  localparam int DET_W = 4;
  // detail bit positions, decoded by software reading det_o
  localparam int DET_GND   = 0;
  localparam int DET_SUPPLY = 1;
  localparam int DET_SHORT = 2;
  localparam int DET_OPEN  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_WAIT = 2'd2,
    ST_PASS = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ldg_retry_timer.sv
module ldg_retry_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int WAIT_MS    = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic done_o
);
  localparam longint TOTAL = longint'(WAIT_MS) * longint'(CYC_PER_MS);
  localparam int     CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(TOTAL);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ldg_chan_seq.sv
module ldg_chan_seq
  import ldg_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int WAIT_MS    = 750
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby_i,
  input  logic             bypass_i,
  input  logic             diag_en_i,
  input  logic             init_pass_i,
  input  logic             req_i,
  input  logic             meas_done_i,
  input  logic             meas_fault_i,
  input  logic [DET_W-1:0] meas_det_i,
  output logic             start_o,
  output logic             report_o,
  output logic             release_o,
  output logic [DET_W-1:0] det_o
);
  seq_state_e       state_q, state_d;
  logic             report_q, report_d;
  logic             start_q, start_d;
  logic             rel_q, rel_d;
  logic [DET_W-1:0] det_q, det_d;
  logic             load, tmr_done, go;

  ldg_retry_timer #(.CYC_PER_MS(CYC_PER_MS), .WAIT_MS(WAIT_MS)) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .done_o (tmr_done)
  );

  assign go = req_i & standby_i;

  always_comb begin
    state_d  = state_q;
    report_d = report_q;
    det_d    = det_q;
    start_d  = 1'b0;
    load     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go && !bypass_i) begin
          if (init_pass_i) begin
            report_d = 1'b1;
            det_d    = '0;
            state_d  = ST_PASS;
          end else if (diag_en_i) begin
            start_d = 1'b1;
            det_d   = '0;
            state_d = ST_TEST;
          end
        end
      end
      ST_TEST: begin
        if (meas_done_i) begin
          if (meas_fault_i) begin
            det_d   = meas_det_i;
            load    = 1'b1;
            state_d = ST_WAIT;
          end else begin
            report_d = 1'b1;
            state_d  = ST_PASS;
          end
        end
      end
      ST_WAIT: begin
        // disable wins over a same-cycle end of wait
        if (!diag_en_i || !req_i) begin
          state_d = ST_IDLE;
        end else if (tmr_done && standby_i) begin
          start_d = 1'b1;
          det_d   = '0;
          state_d = ST_TEST;
        end
      end
      ST_PASS: begin
        if (!req_i) begin
          report_d = 1'b0;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    rel_d = req_i & (report_d | (standby_i & bypass_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      report_q <= 1'b0;
      start_q  <= 1'b0;
      rel_q    <= 1'b0;
      det_q    <= '0;
    end else begin
      state_q  <= state_d;
      report_q <= report_d;
      start_q  <= start_d;
      rel_q    <= rel_d;
      det_q    <= det_d;
    end
  end

  assign start_o   = start_q;
  assign report_o  = report_q;
  assign release_o = rel_q;
  assign det_o     = det_q;
endmodule

// File: rtl/ldg_retry_seq.sv
module ldg_retry_seq
  import ldg_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CYC_PER_MS = 100000,
  parameter int WAIT_MS    = 750
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    standby_i,
  input  logic                    bypass_i,
  input  logic [NUM_CH-1:0]       diag_en_i,
  input  logic [NUM_CH-1:0]       init_pass_i,
  input  logic [NUM_CH-1:0]       req_i,
  output logic [NUM_CH-1:0]       meas_start_o,
  input  logic [NUM_CH-1:0]       meas_done_i,
  input  logic [NUM_CH-1:0]       meas_fault_i,
  input  logic [NUM_CH*DET_W-1:0] meas_det_i,
  output logic [NUM_CH-1:0]       report_o,
  output logic [NUM_CH-1:0]       release_o,
  output logic [NUM_CH*DET_W-1:0] det_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ldg_chan_seq #(.CYC_PER_MS(CYC_PER_MS), .WAIT_MS(WAIT_MS)) seq_i (
      .clk          (clk),
      .rst          (rst),
      .standby_i    (standby_i),
      .bypass_i     (bypass_i),
      .diag_en_i    (diag_en_i[c]),
      .init_pass_i  (init_pass_i[c]),
      .req_i        (req_i[c]),
      .meas_done_i  (meas_done_i[c]),
      .meas_fault_i (meas_fault_i[c]),
      .meas_det_i   (meas_det_i[c*DET_W +: DET_W]),
      .start_o      (meas_start_o[c]),
      .report_o     (report_o[c]),
      .release_o    (release_o[c]),
      .det_o        (det_o[c*DET_W +: DET_W])
    );
  end
endmodule

// File: rtl/ldg_retry_seq_chk.sv
module ldg_retry_seq_chk
  import ldg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    standby_i,
  input logic                    bypass_i,
  input logic [NUM_CH-1:0]       init_pass_i,
  input logic [NUM_CH-1:0]       req_i,
  input logic [NUM_CH-1:0]       meas_start_o,
  input logic [NUM_CH-1:0]       meas_done_i,
  input logic [NUM_CH-1:0]       meas_fault_i,
  input logic [NUM_CH-1:0]       report_o,
  input logic [NUM_CH-1:0]       release_o,
  input logic [NUM_CH*DET_W-1:0] det_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2
    start_standby_chk: assert property (@(posedge clk) disable iff (rst)
      meas_start_o[c] |-> $past(standby_i));
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      meas_start_o[c] |=> !meas_start_o[c]);
    // R7
    det_clear_chk: assert property (@(posedge clk) disable iff (rst)
      meas_start_o[c] |-> (det_o[c*DET_W +: DET_W] == '0));
    // R5
    report_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(report_o[c]) |-> ($past(meas_done_i[c] && !meas_fault_i[c]) || $past(init_pass_i[c])));
    // R6
    release_gate_chk: assert property (@(posedge clk) disable iff (rst)
      release_o[c] |-> (report_o[c] || $past(standby_i && bypass_i)));
    // R10
    hiz_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!req_i[c]) |-> (!release_o[c] && !report_o[c]));
  end
endmodule

bind ldg_retry_seq ldg_retry_seq_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .standby_i    (standby_i),
  .bypass_i     (bypass_i),
  .init_pass_i  (init_pass_i),
  .req_i        (req_i),
  .meas_start_o (meas_start_o),
  .meas_done_i  (meas_done_i),
  .meas_fault_i (meas_fault_i),
  .report_o     (report_o),
  .release_o    (release_o),
  .det_o        (det_o)
);

// File: tb/ldg_retry_seq_tb.sv
module ldg_retry_seq_tb_top;
  localparam int NUM_CH = 2;
  localparam int CPM    = 4;
  localparam int WMS    = 750;
  localparam int TOTAL  = CPM * WMS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic standby = 1'b1, bypass = 1'b0;
  logic [NUM_CH-1:0] diag_en = '1, init_pass = '0, req = '0;
  logic [NUM_CH-1:0] done = '0, fault = '0;
  logic [NUM_CH*4-1:0] mdet = '0;
  logic [NUM_CH-1:0] start, report, rel;
  logic [NUM_CH*4-1:0] det;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ldg_retry_seq #(.NUM_CH(NUM_CH), .CYC_PER_MS(CPM), .WAIT_MS(WMS)) dut_i (
    .clk(clk), .rst(rst), .standby_i(standby), .bypass_i(bypass),
    .diag_en_i(diag_en), .init_pass_i(init_pass), .req_i(req),
    .meas_start_o(start), .meas_done_i(done), .meas_fault_i(fault),
    .meas_det_i(mdet), .report_o(report), .release_o(rel), .det_o(det)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] det_of(input int ch);
    return det[ch*4 +: 4];
  endfunction

  // expected outputs one cycle after a request in each mode
  function automatic logic exp_first_release(input int mode);
    return (mode == 0) || (mode == 1);
  endfunction
  function automatic logic exp_first_start(input int mode);
    return (mode >= 2);
  endfunction

  task automatic give_result(input int ch, input bit f, input logic [3:0] d);
    done[ch] = 1'b1; fault[ch] = f; mdet[ch*4 +: 4] = d;
    @(negedge clk);
    done[ch] = 1'b0; fault[ch] = 1'b0; mdet[ch*4 +: 4] = '0;
  endtask

  task automatic wait_retry(input int ch, output int n);
    n = 0;
    while (!start[ch] && n < TOTAL + 10) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic finish_ep(input int ch);
    req[ch] = 1'b0; bypass = 1'b0; init_pass[ch] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 report after drop", 32'(report[ch]), 0);
    check("R10 release after drop", 32'(rel[ch]), 0);
  endtask

  // mode: 0 bypass, 1 credit, 2 pass, 3 fault then pass
  task automatic run_ep(input int ch, input int mode, input logic [3:0] d);
    int o = 1 - ch;
    int n;
    bypass = (mode == 0); init_pass[ch] = (mode == 1);
    req[ch] = 1'b1;
    @(negedge clk);
    check("R2 start on request", 32'(start[ch]), 32'(exp_first_start(mode)));
    check("R3/R4 first release", 32'(rel[ch]), 32'(exp_first_release(mode)));
    check("R4 credit report", 32'(report[ch]), 32'(mode == 1));
    if (mode >= 2) begin
      check("R7 detail cleared at start", 32'(det_of(ch)), 0);
      @(negedge clk);
      check("R2 start one cycle", 32'(start[ch]), 0);
      give_result(ch, mode == 3, d);
      if (mode == 2) begin
        check("R5 report on pass", 32'(report[ch]), 1);
        check("R5 release on pass", 32'(rel[ch]), 1);
      end else begin
        check("R6 report held low", 32'(report[ch]), 0);
        check("R6 detail latched", 32'(det_of(ch)), 32'(d));
        check("R6 release held", 32'(rel[ch]), 0);
        wait_retry(ch, n);
        check("R8 retry spacing", 32'(n), 32'(TOTAL + 1));
        check("R7 detail cleared at retry", 32'(det_of(ch)), 0);
        @(negedge clk);
        give_result(ch, 1'b0, 4'h0);
        check("R5 report after retry", 32'(report[ch]), 1);
        check("R5 release after retry", 32'(rel[ch]), 1);
      end
    end
    check("R11 other report", 32'(report[o]), 0);
    check("R11 other release", 32'(rel[o]), 0);
    check("R11 other start", 32'(start[o]), 0);
    finish_ep(ch);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 reset start", 32'(start), 0);
    check("R1 reset report", 32'(report), 0);
    check("R1 reset release", 32'(rel), 0);
    check("R1 reset detail", 32'(det), 0);

    // R2: standby low blocks the start
    standby = 1'b0; req[0] = 1'b1;
    seen = 0;
    repeat (4) begin @(negedge clk); if (start[0]) seen = 1; end
    check("R2 no start while standby low", 32'(seen), 0);
    check("R2 no release while standby low", 32'(rel[0]), 0);
    standby = 1'b1;
    @(negedge clk);
    check("R2 start once standby high", 32'(start[0]), 1);
    @(negedge clk);
    give_result(0, 1'b0, 4'h0);
    check("R5 report", 32'(report[0]), 1);
    finish_ep(0);

    // directed modes on channel 0
    for (int m = 0; m < 4; m++) run_ep(0, m, 4'b0101);

    // R9: disable in the same cycle the wait ends
    req[1] = 1'b1;
    @(negedge clk);
    check("R2 start ch1", 32'(start[1]), 1);
    @(negedge clk);
    give_result(1, 1'b1, 4'b1010);
    repeat (TOTAL) @(negedge clk);
    diag_en[1] = 1'b0;
    @(negedge clk);
    check("R9 no retry when disabled at expiry", 32'(start[1]), 0);
    check("R9 detail kept", 32'(det_of(1)), 32'h0000000A);
    seen = 0;
    repeat (6) begin @(negedge clk); if (start[1]) seen = 1; end
    check("R9 retry cancelled", 32'(seen), 0);
    check("R9 channel held", 32'(rel[1]), 0);
    req[1] = 1'b0;
    @(negedge clk);
    diag_en[1] = 1'b1;
    @(negedge clk);
    check("R9 detail kept after idle", 32'(det_of(1)), 32'h0000000A);

    // R8: standby low at end of wait defers the retry
    req[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    give_result(0, 1'b1, 4'b0001);
    standby = 1'b0;
    seen = 0;
    repeat (TOTAL + 5) begin @(negedge clk); if (start[0]) seen = 1; end
    check("R8 retry deferred by standby", 32'(seen), 0);
    check("R6 held during fault", 32'(rel[0]), 0);
    standby = 1'b1;
    @(negedge clk);
    check("R8 retry after standby", 32'(start[0]), 1);
    @(negedge clk);
    give_result(0, 1'b0, 4'h0);
    check("R5 report after deferred retry", 32'(report[0]), 1);
    finish_ep(0);

    // random episodes
    for (int k = 0; k < 10; k++) begin
      int ch = int'($urandom % 2);
      int md = int'($urandom % 4);
      logic [3:0] d = 4'(($urandom % 15) + 1);
      run_ep(ch, md, d);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule